// File: doc/BRIEF.md
# Display Memory DMA Transfer Engine

This block sits between an external byte-wide DMA controller and a display memory organised as 16-bit words. A graphics controller hands it a DMA-read or DMA-write command together with two figure parameters, a start word address, a drawing direction, a line pitch and a write mask. From these the block works out how many bytes the transfer needs and raises its request line. It then serves exactly one byte for each acknowledge strobe until that count is used up.

On reads it fetches words from memory and returns whole words or single bytes. On writes it builds words from incoming bytes and updates memory in one cycle, reading the old word and writing the new one. The update can replace, XOR, clear or set bits. After each word access the word address moves one step in the programmed direction, where a vertical step is one pitch. The address wraps at the top of the address space. When the last byte has been served, the request drops and the block pulses a signal that tells the controller to reload its figure parameters.

Top module: `gdma_xfer`

## Requirements
- R1: Command byte bits 4:3 select the transfer type (0 whole word, 2 low byte, 3 high byte) and bits 1:0 select the modify op. Type 1 is invalid: it never raises `dma_req`, never touches memory, and pulses `fig_clr` for one cycle in the cycle after the command.
- R2: A DMA-read command runs for (DC+1)*(D+2) acknowledged bytes and a DMA-write command for (DC+1)*(D+1). The request stays high until exactly that many strobes have been taken.
- R3: After reset `dma_req` is low. A valid command accepted while idle raises `dma_req` in the next cycle. A command presented while a transfer is running is ignored and changes neither its length nor its settings.
- R4: In the cycle after the final acknowledged byte, `dma_req` is low and `fig_clr` is high for that one cycle only.
- R5: On a word-type read, an acknowledge taken with an even remaining count fetches the word at the current address and returns its low byte. One taken with an odd count returns the high byte of the word last fetched. `dma_rbyte` shows the result from the cycle after the strobe until the next read strobe.
- R6: On a low-byte or high-byte read, every acknowledge fetches a new word and returns bits 7:0 (type 2) or bits 15:8 (type 3).
- R7: On a word-type write, an acknowledge with an even remaining count stores the byte as the low half. One with an odd count supplies the high half, and the assembled word ANDed with the write mask is applied to memory.
- R8: On a byte-type write, the byte, placed in the low lane (type 2) or the high lane (type 3) and masked, modifies only that lane. The other byte of the word keeps its old value.
- R9: Modify op 0 writes the masked data, 1 XORs it into the old contents, 2 clears the bits where it is 1, and 3 sets the bits where it is 1.
- R10: After every word access the address advances by dx + dy*pitch, modulo 2^18. Directions 0..7 give (dx,dy) = (0,+1), (+1,+1), (+1,0), (+1,-1), (0,-1), (-1,-1), (-1,0), (-1,+1).
- R11: An acknowledge strobe while no transfer is active is ignored: no memory access, and `dma_rbyte` is unchanged.
- R12: `mem_rd` and `mem_we` are high only in the cycle of an acknowledge that accesses a word. Every write is accompanied by a read of the same address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = DMA-write command, 0 = DMA-read command |
| cmd_code | input | 8 | Command byte: type in bits 4:3, modify op in bits 1:0 |
| fig_dc | input | DC_W | Figure repeat parameter DC |
| fig_d | input | D_W | Figure parameter D |
| start_addr | input | ADDR_W | Word address where the transfer starts |
| dir | input | 3 | Drawing direction code |
| pitch | input | PITCH_W | Words per display line |
| wmask | input | 16 | Write mask |
| dma_req | output | 1 | DMA request / transfer-active status |
| dma_ack | input | 1 | Single-cycle acknowledge strobe |
| dma_wbyte | input | 8 | Byte supplied with a write acknowledge |
| dma_rbyte | output | 8 | Byte returned for a read acknowledge |
| fig_clr | output | 1 | One-cycle pulse: figure parameters to be reset |
| mem_addr | output | ADDR_W | Display memory word address |
| mem_rd | output | 1 | Memory read in this cycle |
| mem_rdata | input | 16 | Asynchronous read data for mem_addr |
| mem_we | output | 1 | Memory write in this cycle |
| mem_wdata | output | 16 | Word to write |

## Verification
Some rules are checked by the assertions on every cycle: the remaining count is never zero while busy, the busy state and count hold between strobes, the end of a transfer coincides with `fig_clr`, an invalid command never starts a transfer, memory stays quiet while idle with every write paired with a read, and the address moves only on a load or a word step. The actual byte values, the parity-driven low/high sequencing, the mask and modify results, the direction table with address wrap, and the exact transfer lengths can be shown only by the bench's scenarios. The bench compares these against its behavioural model and against values worked out by hand.

// File: rtl/gdma_pkg.sv
package gdma_pkg;
   localparam int BYTE_W = 8;
   localparam int LANES  = 2;
   localparam int WORD_W = BYTE_W * LANES;

   typedef enum logic [1:0] {
      XT_WORD = 2'd0,
      XT_BAD  = 2'd1,
      XT_LOW  = 2'd2,
      XT_HIGH = 2'd3
   } xtype_e;

   typedef enum logic [1:0] {
      OP_REPL = 2'd0,
      OP_XOR  = 2'd1,
      OP_CLR  = 2'd2,
      OP_SET  = 2'd3
   } mop_e;

   // step encoding: 2'b01 = +1, 2'b11 = -1, 2'b00 = none
   function automatic logic [1:0] dir_dx(input logic [2:0] d);
      case (d)
         3'd1, 3'd2, 3'd3: dir_dx = 2'b01;
         3'd5, 3'd6, 3'd7: dir_dx = 2'b11;
         default:          dir_dx = 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] dir_dy(input logic [2:0] d);
      case (d)
         3'd0, 3'd1, 3'd7: dir_dy = 2'b01;
         3'd3, 3'd4, 3'd5: dir_dy = 2'b11;
         default:          dir_dy = 2'b00;
      endcase
   endfunction
endpackage

// File: rtl/gdma_modify.sv
module gdma_modify
   import gdma_pkg::*;
(
   input  mop_e              op,
   input  logic [WORD_W-1:0] old_w,
   input  logic [WORD_W-1:0] data_w,
   input  logic [LANES-1:0]  lane_en,
   output logic [WORD_W-1:0] new_w
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] o, dd, r;
      assign o  = old_w[g*BYTE_W +: BYTE_W];
      assign dd = data_w[g*BYTE_W +: BYTE_W];
      always_comb begin
         case (op)
            OP_REPL: r = dd;
            OP_XOR:  r = o ^ dd;
            OP_CLR:  r = o & ~dd;
            default: r = o | dd;
         endcase
      end
      assign new_w[g*BYTE_W +: BYTE_W] = lane_en[g] ? r : o;
   end
endmodule

// File: rtl/gdma_addr.sv
module gdma_addr
   import gdma_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int PITCH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic [2:0]         load_dir,
   input  logic [PITCH_W-1:0] load_pitch,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr
);
   if (PITCH_W >= ADDR_W) begin : g_bad_pitch
      $error("gdma_addr: PITCH_W must be narrower than ADDR_W");
   end

   logic [2:0]         dir_q;
   logic [PITCH_W-1:0] pitch_q;
   logic [ADDR_W-1:0]  pw, xs, ys;

   assign pw = ADDR_W'(pitch_q);

   always_comb begin
      case (dir_dx(dir_q))
         2'b01:   xs = ADDR_W'(1);
         2'b11:   xs = '1;
         default: xs = '0;
      endcase
      case (dir_dy(dir_q))
         2'b01:   ys = pw;
         2'b11:   ys = '0 - pw;
         default: ys = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr    <= '0;
         dir_q   <= '0;
         pitch_q <= '0;
      end else if (load) begin
         addr    <= load_addr;
         dir_q   <= load_dir;
         pitch_q <= load_pitch;
      end else if (step) begin
         addr <= addr + xs + ys;
      end
   end

   // R10: address moves only on a load or a word step
   a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step |=> $stable(addr));
endmodule

// File: rtl/gdma_cmd.sv
module gdma_cmd
   import gdma_pkg::*;
#(
   parameter int DC_W  = 14,
   parameter int D_W   = 14,
   parameter int CNT_W = DC_W + D_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [7:0]       cmd_code,
   input  logic [DC_W-1:0]  dc,
   input  logic [D_W-1:0]   d,
   input  logic             beat,
   output logic             busy,
   output logic             is_write,
   output xtype_e           xtype,
   output mop_e             mop,
   output logic [CNT_W-1:0] remain,
   output logic             load,
   output logic             fig_clr
);
   if (CNT_W < DC_W + D_W + 2) begin : g_bad_cnt
      $error("gdma_cmd: CNT_W too narrow for the transfer length");
   end

   logic             accept, bad;
   logic [DC_W:0]    nwords;
   logic [D_W:0]     per_word;
   logic [CNT_W-1:0] len;
   logic             unused_code;

   assign unused_code = ^{cmd_code[7:5], cmd_code[2]};
   assign accept   = cmd_valid & ~busy;
   assign bad      = (xtype_e'(cmd_code[4:3]) == XT_BAD);
   assign load     = accept & ~bad;
   assign nwords   = {1'b0, dc} + 1'b1;
   assign per_word = {1'b0, d} + (cmd_write ? (D_W+1)'(1) : (D_W+1)'(2));
   assign len      = CNT_W'(nwords) * CNT_W'(per_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         is_write <= 1'b0;
         xtype    <= XT_WORD;
         mop      <= OP_REPL;
         remain   <= '0;
         fig_clr  <= 1'b0;
      end else begin
         fig_clr <= 1'b0;
         if (load) begin
            busy     <= 1'b1;
            is_write <= cmd_write;
            xtype    <= xtype_e'(cmd_code[4:3]);
            mop      <= mop_e'(cmd_code[1:0]);
            remain   <= len;
         end else if (accept && bad) begin
            fig_clr <= 1'b1;
         end else if (beat) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
               busy    <= 1'b0;
               fig_clr <= 1'b1;
            end
         end
      end
   end

   // R2: a running transfer always has bytes left
   a_r2_remain_live: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> remain != '0);
   // R3: busy state and count hold between strobes
   a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !beat |=> busy && $stable(remain));
   // R4: the end of a transfer comes with the parameter-reset pulse
   a_r4_clr_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> fig_clr);
   // R1: an invalid type never starts a transfer
   a_r1_bad_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      accept && bad |=> !busy);
endmodule

// File: rtl/gdma_xfer.sv
module gdma_xfer
   import gdma_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int DC_W    = 14,
   parameter int D_W     = 14,
   parameter int PITCH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_write,
   input  logic [7:0]         cmd_code,
   input  logic [DC_W-1:0]    fig_dc,
   input  logic [D_W-1:0]     fig_d,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic [2:0]         dir,
   input  logic [PITCH_W-1:0] pitch,
   input  logic [15:0]        wmask,
   output logic               dma_req,
   input  logic               dma_ack,
   input  logic [7:0]         dma_wbyte,
   output logic [7:0]         dma_rbyte,
   output logic               fig_clr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   input  logic [15:0]        mem_rdata,
   output logic               mem_we,
   output logic [15:0]        mem_wdata
);
   localparam int CNT_W = DC_W + D_W + 2;

   if (WORD_W != 16 || ADDR_W < 2 || DC_W < 1 || D_W < 1) begin : g_bad_cfg
      $error("gdma_xfer: unsupported parameter set");
   end

   logic              busy, is_write, load, beat, wordacc;
   xtype_e            xtype;
   mop_e              mop;
   logic [CNT_W-1:0]  remain;
   logic [LANES-1:0]  lanes;
   logic [WORD_W-1:0] mask_q, held_q, data_w;
   logic [BYTE_W-1:0] lo_q, rbyte_q;

   gdma_cmd #(.DC_W(DC_W), .D_W(D_W), .CNT_W(CNT_W)) cmd_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_code(cmd_code), .dc(fig_dc), .d(fig_d), .beat(beat),
      .busy(busy), .is_write(is_write), .xtype(xtype), .mop(mop),
      .remain(remain), .load(load), .fig_clr(fig_clr)
   );

   gdma_addr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) addr_i (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
      .load_dir(dir), .load_pitch(pitch), .step(beat & wordacc),
      .addr(mem_addr)
   );

   assign beat = busy & dma_ack;

   // word access: byte types always, word type by parity of the remaining count
   always_comb begin
      case (xtype)
         XT_WORD: begin wordacc = is_write ? remain[0] : ~remain[0]; lanes = 2'b11; end
         XT_LOW:  begin wordacc = 1'b1; lanes = 2'b01; end
         XT_HIGH: begin wordacc = 1'b1; lanes = 2'b10; end
         default: begin wordacc = 1'b0; lanes = 2'b00; end
      endcase
      case (xtype)
         XT_WORD: data_w = {dma_wbyte, lo_q} & mask_q;
         XT_LOW:  data_w = {8'h00, dma_wbyte} & mask_q;
         default: data_w = {dma_wbyte, 8'h00} & mask_q;
      endcase
   end

   gdma_modify mod_i (
      .op(mop), .old_w(mem_rdata), .data_w(data_w), .lane_en(lanes),
      .new_w(mem_wdata)
   );

   assign mem_rd    = beat & wordacc;
   assign mem_we    = beat & wordacc & is_write;
   assign dma_req   = busy;
   assign dma_rbyte = rbyte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         held_q  <= '0;
         lo_q    <= '0;
         rbyte_q <= '0;
      end else begin
         if (load) mask_q <= wmask;
         if (beat && !is_write) begin
            if (wordacc) begin
               held_q  <= mem_rdata;
               rbyte_q <= (xtype == XT_HIGH) ? mem_rdata[15:8] : mem_rdata[7:0];
            end else begin
               rbyte_q <= held_q[15:8];
            end
         end
         if (beat && is_write && !wordacc) lo_q <= dma_wbyte;
      end
   end

   // R11: no memory traffic while idle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_req |-> !mem_rd && !mem_we);
   // R11: returned byte frozen while idle
   a_r11_rbyte_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_req |=> $stable(dma_rbyte));
   // R12: every write is a read-modify-write of the same word
   a_r12_we_has_rd: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_rd);
endmodule

// File: tb/gdma_xfer_tb.sv
module gdma_xfer_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [13:0] fig_dc = '0, fig_d = '0;
   logic [17:0] start_addr = '0;
   logic [2:0]  dir = '0;
   logic [7:0]  pitch = '0;
   logic [15:0] wmask = '0;
   logic        dma_req, dma_ack = 1'b0, fig_clr, mem_rd, mem_we;
   logic [7:0]  dma_wbyte = '0, dma_rbyte;
   logic [17:0] mem_addr;
   logic [15:0] mem_rdata, mem_wdata;

   always #(CLK_P/2) clk = ~clk;

   gdma_xfer dut_i (.*);

   int checks = 0, fails = 0;
   bit done = 0, cmp_on = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(int a);
      return 16'(a * 7) ^ 16'hA5C3;
   endfunction

   // memory the design talks to
   logic [15:0] dut_mem[int];
   logic [15:0] ref_mem[int];
   bit wr_tick = 0;
   logic c_we; logic [17:0] c_a; logic [15:0] c_d;

   function automatic logic [15:0] rdut(int a);
      return dut_mem.exists(a) ? dut_mem[a] : pat(a);
   endfunction
   function automatic logic [15:0] rref(int a);
      return ref_mem.exists(a) ? ref_mem[a] : pat(a);
   endfunction

   always @(mem_addr, wr_tick) mem_rdata = rdut(int'(mem_addr));
   always @(negedge clk) begin
      #(CLK_P/4);
      c_we = mem_we; c_a = mem_addr; c_d = mem_wdata;
   end
   always @(posedge clk) if (c_we === 1'b1) begin
      dut_mem[int'(c_a)] = c_d;
      wr_tick = ~wr_tick;
   end

   // behavioural reference model
   bit m_busy = 0, m_clr = 0, m_wr = 0, acc;
   int m_cnt = 0, m_type = 0, m_op = 0, m_addr = 0, m_dir = 0, m_pitch = 0;
   logic [15:0] m_mask = 0, m_held = 0, dw, ow, nw;
   logic [7:0] m_lo = 0, m_rb = 0, ob, db, rb;

   function automatic int dxf(int d);
      return (d >= 1 && d <= 3) ? 1 : (d >= 5) ? -1 : 0;
   endfunction
   function automatic int dyf(int d);
      return (d <= 1 || d == 7) ? 1 : (d >= 3 && d <= 5) ? -1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_clr = 0; m_rb = 0; m_cnt = 0; m_held = 0; m_lo = 0;
      end else begin
         m_clr = 0;
         if (m_busy && dma_ack) begin
            acc = (m_type == 0) ? (m_wr ? (m_cnt % 2 == 1) : (m_cnt % 2 == 0)) : 1'b1;
            if (!m_wr) begin
               if (acc) begin
                  m_held = rref(m_addr);
                  m_rb = (m_type == 3) ? m_held[15:8] : m_held[7:0];
               end else m_rb = m_held[15:8];
            end else if (!acc) m_lo = dma_wbyte;
            else begin
               dw = (m_type == 0) ? {dma_wbyte, m_lo} : (m_type == 2) ? {8'h00, dma_wbyte} : {dma_wbyte, 8'h00};
               dw &= m_mask;
               ow = rref(m_addr);
               nw = ow;
               for (int b = 0; b < 2; b++) begin
                  if (m_type == 0 || (m_type == 2 && b == 0) || (m_type == 3 && b == 1)) begin
                     ob = ow[b*8 +: 8]; db = dw[b*8 +: 8];
                     case (m_op)
                        0: rb = db;
                        1: rb = ob ^ db;
                        2: rb = ob & ~db;
                        default: rb = ob | db;
                     endcase
                     nw[b*8 +: 8] = rb;
                  end
               end
               ref_mem[m_addr] = nw;
            end
            if (acc) m_addr = (m_addr + dxf(m_dir) + dyf(m_dir) * m_pitch) & 32'h3FFFF;
            m_cnt--;
            if (m_cnt == 0) begin m_busy = 0; m_clr = 1; end
         end else if (cmd_valid && !m_busy) begin
            m_type = int'(cmd_code[4:3]); m_op = int'(cmd_code[1:0]);
            if (m_type == 1) m_clr = 1;
            else begin
               m_busy = 1; m_wr = cmd_write;
               m_cnt = (int'(fig_dc) + 1) * (int'(fig_d) + (cmd_write ? 1 : 2));
               m_addr = int'(start_addr); m_dir = int'(dir); m_pitch = int'(pitch); m_mask = wmask;
            end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) if (cmp_on) begin
      chk(dma_req === m_busy, "R2/R3/R4 model dma_req", 32'(dma_req), 32'(m_busy));
      chk(fig_clr === m_clr, "R1/R4 model fig_clr", 32'(fig_clr), 32'(m_clr));
      chk(dma_rbyte === m_rb, "R5/R6 model dma_rbyte", 32'(dma_rbyte), 32'(m_rb));
   end

   task automatic issue(input bit wr, input logic [7:0] code, input int dc, input int d,
                        input int a, input int dr, input int p, input logic [15:0] mk);
      @(negedge clk);
      cmd_valid = 1; cmd_write = wr; cmd_code = code; fig_dc = 14'(dc); fig_d = 14'(d);
      start_addr = 18'(a); dir = 3'(dr); pitch = 8'(p); wmask = mk;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic ack(input logic [7:0] wb);
      dma_ack = 1; dma_wbyte = wb;
      @(negedge clk);
      dma_ack = 0;
   endtask

   task automatic drain(output int n);
      n = 0;
      while (dma_req && n < 100) begin ack(8'(n + 1)); n++; end
   endtask

   task automatic mem_agree(input string tag);
      foreach (ref_mem[k]) chk(rdut(k) === ref_mem[k], tag, 32'(rdut(k)), 32'(ref_mem[k]));
      foreach (dut_mem[k]) chk(rref(k) === dut_mem[k], tag, 32'(dut_mem[k]), 32'(rref(k)));
   endtask

   int n, nmem;
   logic [7:0] held;

   initial begin
      repeat (3) @(negedge clk);
      // R3 reset state
      chk(dma_req === 1'b0, "R3 reset dma_req", 32'(dma_req), 0);
      chk(fig_clr === 1'b0, "R4 reset fig_clr", 32'(fig_clr), 0);
      chk(dma_rbyte === 8'h00, "R5 reset dma_rbyte", 32'(dma_rbyte), 0);
      rst_n = 1; cmp_on = 1;
      @(negedge clk);

      // R5 word read, 2 words along +x
      issue(0, 8'h00, 1, 0, 50, 2, 0, 16'hFFFF);
      chk(dma_req === 1'b1, "R3 req after command", 32'(dma_req), 1);
      ack(0); chk(dma_rbyte === pat(50)[7:0], "R5 even count low byte", 32'(dma_rbyte), 32'(pat(50)[7:0]));
      ack(0); chk(dma_rbyte === pat(50)[15:8], "R5 odd count high byte", 32'(dma_rbyte), 32'(pat(50)[15:8]));
      ack(0); chk(dma_rbyte === pat(51)[7:0], "R5 next word low", 32'(dma_rbyte), 32'(pat(51)[7:0]));
      ack(0); chk(dma_rbyte === pat(51)[15:8], "R5 next word high", 32'(dma_rbyte), 32'(pat(51)[15:8]));
      chk(dma_req === 1'b0 && fig_clr === 1'b1, "R4 end of transfer", {dma_req, fig_clr}, 2'b01);
      @(negedge clk);
      chk(fig_clr === 1'b0, "R4 single pulse", 32'(fig_clr), 0);

      // R6 byte reads down a column, pitch 40
      issue(0, 8'h10, 0, 1, 70, 0, 40, 16'hFFFF);
      for (int i = 0; i < 3; i++) begin
         ack(0);
         chk(dma_rbyte === pat(70 + 40*i)[7:0], "R6 low byte read", 32'(dma_rbyte), 32'(pat(70 + 40*i)[7:0]));
      end
      issue(0, 8'h18, 0, 1, 170, 4, 40, 16'hFFFF);
      for (int i = 0; i < 3; i++) begin
         ack(0);
         chk(dma_rbyte === pat(170 - 40*i)[15:8], "R6 high byte read", 32'(dma_rbyte), 32'(pat(170 - 40*i)[15:8]));
      end

      // R7 / R9 word writes with the four ops
      issue(1, 8'h00, 0, 1, 200, 2, 0, 16'h0FF0); ack(8'h3C); ack(8'h5A);
      chk(rdut(200) === 16'h0A30, "R7 replace with mask", 32'(rdut(200)), 32'h0A30);
      issue(1, 8'h01, 0, 1, 100, 2, 0, 16'hFFFF); ack(8'h3C); ack(8'h5A);
      chk(rdut(100) === (pat(100) ^ 16'h5A3C), "R9 xor", 32'(rdut(100)), 32'(pat(100) ^ 16'h5A3C));
      issue(1, 8'h02, 0, 1, 300, 2, 0, 16'hFFFF); ack(8'h3C); ack(8'h5A);
      chk(rdut(300) === (pat(300) & ~16'h5A3C), "R9 clear", 32'(rdut(300)), 32'(pat(300) & ~16'h5A3C));
      issue(1, 8'h03, 0, 1, 400, 2, 0, 16'hFFFF); ack(8'h3C); ack(8'h5A);
      chk(rdut(400) === (pat(400) | 16'h5A3C), "R9 set", 32'(rdut(400)), 32'(pat(400) | 16'h5A3C));

      // R8 byte writes leave the other lane
      issue(1, 8'h10, 0, 0, 500, 2, 0, 16'hFFFF); ack(8'h77);
      chk(rdut(500) === {pat(500)[15:8], 8'h77}, "R8 low lane", 32'(rdut(500)), 32'({pat(500)[15:8], 8'h77}));
      issue(1, 8'h18, 0, 0, 600, 2, 0, 16'hFFFF); ack(8'h99);
      chk(rdut(600) === {8'h99, pat(600)[7:0]}, "R8 high lane", 32'(rdut(600)), 32'({8'h99, pat(600)[7:0]}));

      // R10 wrap below zero and diagonal step
      issue(1, 8'h00, 1, 1, 0, 6, 0, 16'hFFFF); ack(8'h11); ack(8'h22); ack(8'h33); ack(8'h44);
      chk(rdut(0) === 16'h2211, "R10 first word", 32'(rdut(0)), 32'h2211);
      chk(rdut(18'h3FFFF) === 16'h4433, "R10 wrap to top", 32'(rdut(18'h3FFFF)), 32'h4433);
      issue(1, 8'h10, 1, 0, 1000, 3, 40, 16'hFFFF); ack(8'hAB); ack(8'hCD);
      chk(rdut(961)[7:0] === 8'hCD, "R10 diagonal step", 32'(rdut(961)[7:0]), 32'hCD);

      // R1 invalid type
      nmem = dut_mem.num();
      issue(1, 8'h08, 3, 3, 700, 2, 0, 16'hFFFF);
      chk(dma_req === 1'b0, "R1 invalid no request", 32'(dma_req), 0);
      chk(fig_clr === 1'b1, "R1 invalid clears figure", 32'(fig_clr), 1);
      drain(n);
      chk(dut_mem.num() == nmem, "R1 invalid no memory", 32'(dut_mem.num()), 32'(nmem));

      // R2 lengths
      issue(1, 8'h18, 2, 1, 800, 2, 0, 16'hFFFF); drain(n);
      chk(n == 6, "R2 write length", 32'(n), 6);
      issue(0, 8'h00, 0, 1, 820, 2, 0, 16'hFFFF); drain(n);
      chk(n == 3, "R2 read length", 32'(n), 3);

      // R3 command while busy is ignored
      issue(0, 8'h10, 0, 2, 900, 2, 0, 16'hFFFF);
      issue(1, 8'h00, 5, 5, 950, 6, 0, 16'hFFFF);
      ack(0);
      chk(dma_rbyte === pat(900)[7:0], "R3 first command kept", 32'(dma_rbyte), 32'(pat(900)[7:0]));
      n = 1;
      while (dma_req && n < 100) begin ack(0); n++; end
      chk(n == 4, "R3 length unchanged", 32'(n), 4);

      // R11 idle strobes
      held = dma_rbyte; nmem = dut_mem.num();
      repeat (3) ack(8'hEE);
      chk(dma_rbyte === held, "R11 idle rbyte", 32'(dma_rbyte), 32'(held));
      chk(dut_mem.num() == nmem, "R11 idle memory", 32'(dut_mem.num()), 32'(nmem));

      // R12 memory image agrees with the model
      @(negedge clk);
      mem_agree("R7/R8/R9/R10/R12 memory image");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R2 transfer hung actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule